// File: doc/BRIEF.md
# Per-Bank DRAM Row Timing Tracker

This block sits on the controller side of an eight-bank DDR2-class memory. It keeps a separate timing record for each bank. The scheduler presents one command per cycle: activate, read, write or precharge, each with a bank index. Read and write may also ask for auto-precharge. For every bank the tracker says whether an activate, a column access or a precharge would be legal on the next clock edge. It also remembers whether the bank is open and, if so, which row.

The tracker enforces four minimum intervals, all counted in clock cycles:
- activate to column access;
- precharge to activate;
- activate to precharge (the minimum active time);
- activate to activate in the same bank.

A speed-bin input selects the clock period and the nanosecond limits. The tracker turns each limit into cycles by ceiling division and loads it into a down-counter for that bank. A command that breaks a rule sets a sticky error flag and leaves every bank record unchanged.

Top module: `bank_timing_tracker`

## Requirements
- R1: After reset, all banks are closed, `act_ok` is all ones, `col_ok`, `pre_ok` and `err` are zero.
- R2: A legal activate (`cmd_op`=0) opens the addressed bank and records `cmd_row`; `q_row` returns the recorded row of bank `q_bank`.
- R3: A read (`cmd_op`=1) or write (`cmd_op`=2) is legal, and `col_ok` is set, only when the bank is open, has no auto-precharge pending, and at least tRCD cycles have passed since its activate.
- R4: A precharge (`cmd_op`=3) is legal, and `pre_ok` is set, only on an open bank with no auto-precharge pending and at least tRAS cycles after its activate; it closes the bank.
- R5: An activate is legal, and `act_ok` is set, only on a closed bank at least tRC cycles after that bank's previous activate and at least tRP cycles after the edge that closed it.
- R6: Cycle counts are ceil(ns / period) for the bin present when the interval starts. The bins give these values for tRCD/tRP/tRAS/tRC:
  - bin 0 (5 ns): 3/3/8/11
  - bin 1 (3.75 ns): 4/4/12/16
  - bin 2 (3 ns): 5/5/15/20
  - bin 3 (3 ns): 4/4/15/19
- R7: A legal read or write with `cmd_ap`=1 blocks further column and precharge commands to that bank. The bank then closes at the first later edge at which tRAS has elapsed, and tRP counts from that edge.
- R8: A command that is not legal for its bank sets `err`, which stays set until reset, and changes no bank state.
- R9: Banks are independent: a command to one bank does not alter the flags, state or row of any other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_bin | input | 2 | Speed bin selecting period and intervals |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| cmd_ap | input | 1 | Auto-precharge with read or write |
| cmd_bank | input | 3 | Target bank |
| cmd_row | input | 17 | Row address for activate |
| q_bank | input | 3 | Bank whose open row is reported |
| q_row | output | 17 | Recorded row of bank `q_bank` |
| bank_open | output | 8 | Per-bank open flag |
| act_ok | output | 8 | Activate legal next edge |
| col_ok | output | 8 | Read/write legal next edge |
| pre_ok | output | 8 | Precharge legal next edge |
| err | output | 1 | Sticky illegal-command flag |

## Verification
The hardest case to reach is an auto-precharge issued well before tRAS has run out. In that case the bank stays open, yet it refuses every command until the implied precharge lands. After that, a tRP window and the longer tRC window overlap. The stimulus reaches this case by issuing a column command with auto-precharge as soon as `col_ok` rises. It then keeps the stream busy with random commands, chosen from what the bench model says is legal, across all banks and every speed bin. A behavioural model of edge time stamps predicts every flag on every cycle.

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker #(
  parameter int BANKS = 8,
  parameter int ROW_W = 17,
  parameter int CNT_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               speed_bin,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic                     cmd_ap,
  input  logic [$clog2(BANKS)-1:0] cmd_bank,
  input  logic [ROW_W-1:0]         cmd_row,
  input  logic [$clog2(BANKS)-1:0] q_bank,
  output logic [ROW_W-1:0]         q_row,
  output logic [BANKS-1:0]         bank_open,
  output logic [BANKS-1:0]         act_ok,
  output logic [BANKS-1:0]         col_ok,
  output logic [BANKS-1:0]         pre_ok,
  output logic                     err
);
  localparam int BANK_W = $clog2(BANKS);

  function automatic logic [CNT_W-1:0] to_load(input int ns, input int per_ps);
    int c;
    c = (ns * 1000 + per_ps - 1) / per_ps;
    return CNT_W'(c - 1);
  endfunction

  int per_ps, rcd_ns, ras_ns, rc_ns;
  logic [CNT_W-1:0] ld_rcd, ld_rp, ld_ras, ld_rc;

  always_comb begin
    case (speed_bin)
      2'd0:    begin per_ps = 5000; rc_ns = 55; end
      2'd1:    begin per_ps = 3750; rc_ns = 60; end
      2'd2:    begin per_ps = 3000; rc_ns = 60; end
      default: begin per_ps = 3000; rc_ns = 57; end
    endcase
    rcd_ns = (speed_bin == 2'd3) ? 12 : 15;
    ras_ns = (speed_bin == 2'd0) ? 40 : 45;
    ld_rcd = to_load(rcd_ns, per_ps);
    ld_rp  = to_load(rcd_ns, per_ps);
    ld_ras = to_load(ras_ns, per_ps);
    ld_rc  = to_load(rc_ns, per_ps);
  end

  logic [CNT_W-1:0] rcd_c [BANKS];
  logic [CNT_W-1:0] rp_c  [BANKS];
  logic [CNT_W-1:0] ras_c [BANKS];
  logic [CNT_W-1:0] rc_c  [BANKS];
  logic [ROW_W-1:0] row_q [BANKS];
  logic [BANKS-1:0] ap_q;

  for (genvar g = 0; g < BANKS; g++) begin : g_flag
    assign act_ok[g] = !bank_open[g] && rp_c[g] == '0 && rc_c[g] == '0;
    assign col_ok[g] = bank_open[g] && !ap_q[g] && rcd_c[g] == '0;
    assign pre_ok[g] = bank_open[g] && !ap_q[g] && ras_c[g] == '0;
  end

  wire is_act = cmd_op == 2'd0;
  wire is_col = cmd_op == 2'd1 || cmd_op == 2'd2;
  wire legal  = is_act ? act_ok[cmd_bank] : is_col ? col_ok[cmd_bank] : pre_ok[cmd_bank];
  wire go     = cmd_valid && legal;

  assign q_row = row_q[q_bank];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err       <= 1'b0;
      bank_open <= '0;
      ap_q      <= '0;
      for (int i = 0; i < BANKS; i++) begin
        rcd_c[i] <= '0; rp_c[i] <= '0; ras_c[i] <= '0; rc_c[i] <= '0;
        row_q[i] <= '0;
      end
    end else begin
      if (cmd_valid && !legal) err <= 1'b1;
      for (int i = 0; i < BANKS; i++) begin
        if (rcd_c[i] != '0) rcd_c[i] <= rcd_c[i] - 1'b1;
        if (rp_c[i]  != '0) rp_c[i]  <= rp_c[i]  - 1'b1;
        if (ras_c[i] != '0) ras_c[i] <= ras_c[i] - 1'b1;
        if (rc_c[i]  != '0) rc_c[i]  <= rc_c[i]  - 1'b1;
        if (ap_q[i] && ras_c[i] == '0) begin
          bank_open[i] <= 1'b0;
          ap_q[i]      <= 1'b0;
          rp_c[i]      <= ld_rp;
        end
        if (go && cmd_bank == BANK_W'(i)) begin
          if (is_act) begin
            bank_open[i] <= 1'b1;
            row_q[i]     <= cmd_row;
            rcd_c[i]     <= ld_rcd;
            ras_c[i]     <= ld_ras;
            rc_c[i]      <= ld_rc;
          end else if (is_col) begin
            if (cmd_ap) ap_q[i] <= 1'b1;
          end else begin
            bank_open[i] <= 1'b0;
            rp_c[i]      <= ld_rp;
          end
        end
      end
    end
  end
endmodule

// File: rtl/bank_timing_tracker_chk.sv
module bank_timing_tracker_chk #(
  parameter int BANKS = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmd_valid,
  input logic [1:0]               cmd_op,
  input logic                     cmd_ap,
  input logic [$clog2(BANKS)-1:0] cmd_bank,
  input logic [BANKS-1:0]         bank_open,
  input logic [BANKS-1:0]         act_ok,
  input logic [BANKS-1:0]         col_ok,
  input logic [BANKS-1:0]         pre_ok,
  input logic                     err
);
  wire ok_now = cmd_op == 2'd0 ? act_ok[cmd_bank] :
                cmd_op == 2'd3 ? pre_ok[cmd_bank] : col_ok[cmd_bank];

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (bank_open == '0 && !err && act_ok == {BANKS{1'b1}}));

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && ok_now) |=> bank_open[$past(cmd_bank)]);

  assert_col_waits_after_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && ok_now) |=> !col_ok[$past(cmd_bank)]);

  assert_pre_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3 && ok_now) |=> !bank_open[$past(cmd_bank)] && !act_ok[$past(cmd_bank)]);

  assert_ap_blocks_col_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op inside {2'd1, 2'd2} && cmd_ap && ok_now)
      |=> !col_ok[$past(cmd_bank)] && !pre_ok[$past(cmd_bank)]);

  assert_illegal_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !ok_now) |=> err);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind bank_timing_tracker bank_timing_tracker_chk #(.BANKS(BANKS)) chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ap(cmd_ap),
  .cmd_bank(cmd_bank), .bank_open(bank_open), .act_ok(act_ok), .col_ok(col_ok),
  .pre_ok(pre_ok), .err(err)
);

// File: tb/bank_timing_tracker_test.sv
module bank_timing_tracker_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] speed_bin = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic cmd_ap = 0;
  logic [2:0] cmd_bank = 0;
  logic [16:0] cmd_row = 0;
  logic [2:0] q_bank = 0;
  logic [16:0] q_row;
  logic [7:0] bank_open, act_ok, col_ok, pre_ok;
  logic err;

  bank_timing_tracker uut (.*);

  always #5 clk = ~clk;

  int T_RCD[4] = '{3, 4, 5, 4};
  int T_RAS[4] = '{8, 12, 15, 15};
  int T_RC[4]  = '{11, 16, 20, 19};

  int tests = 0, fails = 0;
  bit done = 0;

  int cyc;
  bit m_open[8], m_ap[8], m_err;
  int m_row[8], m_ap_e[8], last_act[8], close_e[8], n_rcd[8], n_ras[8], n_rc[8], n_rp[8];

  function automatic bit m_act_ok(int b, int e);
    return !m_open[b] && e - last_act[b] >= n_rc[b] && e - close_e[b] >= n_rp[b];
  endfunction
  function automatic bit m_col_ok(int b, int e);
    return m_open[b] && !m_ap[b] && e - last_act[b] >= n_rcd[b];
  endfunction
  function automatic bit m_pre_ok(int b, int e);
    return m_open[b] && !m_ap[b] && e - last_act[b] >= n_ras[b];
  endfunction
  function automatic bit m_legal(int op, int b, int e);
    if (op == 0) return m_act_ok(b, e);
    if (op == 3) return m_pre_ok(b, e);
    return m_col_ok(b, e);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; m_err = 0;
      for (int b = 0; b < 8; b++) begin
        m_open[b] = 0; m_ap[b] = 0; m_row[b] = 0; m_ap_e[b] = 0;
        last_act[b] = -1000; close_e[b] = -1000;
        n_rcd[b] = 0; n_ras[b] = 0; n_rc[b] = 0; n_rp[b] = 0;
      end
    end else begin
      bit lg;
      int e, b, bi;
      e = cyc; b = cmd_bank; bi = speed_bin;
      lg = cmd_valid && m_legal(cmd_op, b, e);
      if (cmd_valid && !lg) m_err = 1;
      for (int k = 0; k < 8; k++)
        if (m_ap[k] && m_ap_e[k] < e && e - last_act[k] >= n_ras[k]) begin
          m_open[k] = 0; m_ap[k] = 0; close_e[k] = e; n_rp[k] = T_RCD[bi];
        end
      if (lg) begin
        if (cmd_op == 0) begin
          m_open[b] = 1; m_row[b] = cmd_row; last_act[b] = e;
          n_rcd[b] = T_RCD[bi]; n_ras[b] = T_RAS[bi]; n_rc[b] = T_RC[bi];
        end else if (cmd_op == 3) begin
          m_open[b] = 0; close_e[b] = e; n_rp[b] = T_RCD[bi];
        end else if (cmd_ap) begin
          m_ap[b] = 1; m_ap_e[b] = e;
        end
      end
      cyc++;
    end
  end

  task automatic check(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic [7:0] ea, ec, ep, eo;
    for (int b = 0; b < 8; b++) begin
      ea[b] = m_act_ok(b, cyc); ec[b] = m_col_ok(b, cyc);
      ep[b] = m_pre_ok(b, cyc); eo[b] = m_open[b];
    end
    check("R5 act_ok", act_ok, ea);
    check("R3 col_ok", col_ok, ec);
    check("R4 pre_ok", pre_ok, ep);
    check("R2/R7 bank_open", bank_open, eo);
    check("R2 q_row", q_row, m_row[q_bank]);
    check("R8 err", err, m_err);
  end

  task automatic issue(int op, bit ap, int b, int row);
    @(posedge clk); #1;
    cmd_valid = 1; cmd_op = 2'(op); cmd_ap = ap; cmd_bank = 3'(b); cmd_row = 17'(row);
    q_bank = 3'(b);
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset act_ok", act_ok, 8'hFF);
    check("R1 reset col_ok", col_ok, 0);
    check("R1 reset pre_ok", pre_ok, 0);
    check("R1 reset open", bank_open, 0);
    check("R1 reset err", err, 0);

    // R6: measure tRCD and tRAS in cycles for each bin
    for (int bn = 0; bn < 4; bn++) begin
      int k, kc, kp;
      speed_bin = 2'(bn);
      idle(25);
      issue(0, 0, bn, 100 + bn);
      k = 0; kc = 0; kp = 0;
      while (kp == 0 && k < 40) begin
        @(negedge clk); k++;
        if (kc == 0 && col_ok[bn]) kc = k;
        if (pre_ok[bn]) kp = k;
      end
      check("R6 tRCD cycles", kc, T_RCD[bn]);
      check("R6 tRAS cycles", kp, T_RAS[bn]);
      check("R2 row recorded", q_row, 100 + bn);
      issue(3, 0, bn, 0);
    end

    // R9: two banks open together, other untouched
    speed_bin = 0;
    idle(25);
    issue(0, 0, 5, 55);
    issue(0, 0, 2, 22);
    @(negedge clk);
    check("R9 two banks open", bank_open, 8'b0010_0100);
    q_bank = 5; #1;
    check("R9 row of other bank kept", q_row, 55);

    // R7: auto-precharge right at tRCD, before tRAS
    idle(2);
    issue(1, 1, 2, 0);
    @(negedge clk);
    check("R7 col blocked after ap", col_ok[2], 0);
    check("R7 bank still open before tRAS", bank_open[2], 1);
    idle(12);
    @(negedge clk);
    check("R7 bank closed after ap", bank_open[2], 0);

    // R8: illegal commands
    issue(1, 0, 7, 0);
    @(negedge clk);
    check("R8 err after read of closed bank", err, 1);
    check("R8 bank7 unchanged", bank_open[7], 0);
    issue(0, 0, 5, 77);
    q_bank = 5; #1;
    check("R8 row kept after illegal act", q_row, 55);

    // random legal-biased stream across bins
    for (int r = 0; r < 4; r++) begin
      if (r == 2) begin rst_n = 0; idle(2); rst_n = 1; end
      speed_bin = 2'(r);
      for (int i = 0; i < 1500; i++) begin
        @(posedge clk); #1;
        cmd_valid = 0;
        q_bank = 3'($urandom_range(0, 7));
        if ($urandom_range(0, 2) != 0) begin
          int b, op, tries;
          b = $urandom_range(0, 7);
          op = $urandom_range(0, 3);
          tries = 0;
          while ($urandom_range(0, 9) != 0 && !m_legal(op, b, cyc) && tries < 20) begin
            b = $urandom_range(0, 7); op = $urandom_range(0, 3); tries++;
          end
          cmd_valid = 1; cmd_op = 2'(op); cmd_bank = 3'(b);
          cmd_ap = $urandom_range(0, 1) == 1; cmd_row = 17'($urandom);
        end
      end
      @(posedge clk); #1;
      cmd_valid = 0;
      idle(30);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule